// File: doc/BRIEF.md
# Dual-Resolution Acceleration Data Register File

This block is a register file for a 3-axis acceleration sensor with a temperature channel, read and written over a 4-wire serial peripheral interface. A measurement source presents four 12-bit two's-complement values together with a one-cycle valid strobe, and the block captures all four at once. Software reads each value as a full-width pair of bytes or, for the three axes, as a single top-8-bit byte. The short bytes sit next to each other, so a 3-byte burst returns a whole coarse sample. Both views come from the same captured sample and no mode has to be selected.

Each frame starts with a command byte and an address byte, followed by any number of data bytes. The register pointer steps once for each data byte. When the address byte completes, all data registers are copied into a shadow bank. Every byte of that frame comes from the shadow bank, so a burst never mixes two samples. Four writable configuration bytes at the bottom of the map are driven onto an output port. The serial inputs are brought into the system clock domain through synchronizers, so the system clock must run at least eight times faster than SCLK.

Top module: `accel_spi_regs`

## Requirements
- R1: After reset, cfg_bytes is zero, spi_miso is low, and every data register reads as 0x00 until the first sample is captured.
- R2: Addresses 0x0E to 0x15 hold x, y, z and temperature in that order, two bytes each. The lower address holds value[7:0]. The higher address holds four copies of value[11] followed by value[11:8].
- R3: Addresses 0x08, 0x09 and 0x0A hold value[11:4] of x, y and z.
- R4: A single burst covering 0x08 to 0x15 returns a short view and a full view that come from the same sample.
- R5: The interface uses SPI mode 0 and sends MSB first. A frame is a command byte (0x0A for write, 0x0B for read), then an address byte, then data bytes. spi_miso changes after falling SCLK edges.
- R6: The register pointer increments after each data byte and wraps from 0xFF to 0x00.
- R7: A copy of the sample is latched when the address byte completes. A sample_valid pulse during a frame does not change the bytes returned in that frame, and the next frame returns the new sample.
- R8: On a cycle with sample_valid high, all four inputs are captured together. While sample_valid is low, changes on the inputs have no effect.
- R9: Addresses 0x00 to 0x03 are writable configuration bytes. Byte k appears at cfg_bytes[8k+7:8k] and reads back. Writes to any other address are ignored.
- R10: A frame whose command byte is neither 0x0A nor 0x0B writes nothing and drives spi_miso low for the whole frame.
- R11: If chip select rises in the middle of a byte, that partial byte is discarded, and the next frame starts cleanly with a command byte.
- R12: spi_miso is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | One-cycle strobe to capture a new sample |
| accel_x | input | 12 | X-axis value, two's complement |
| accel_y | input | 12 | Y-axis value, two's complement |
| accel_z | input | 12 | Z-axis value, two's complement |
| temp_in | input | 12 | Temperature value, two's complement |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| cfg_bytes | output | 32 | Configuration bytes, byte k at bits 8k+7:8k |

## Verification
The embedded assertions check these properties on every cycle:
- the pointer steps by one after each data byte;
- register writes occur only in the data phase of a write frame;
- the shadow bank and the configuration bytes change only when they are latched or written;
- captured values follow the inputs on a strobe;
- spi_miso stays low in an ignored frame.

Only the bench scenarios can show the rest:
- the address-to-field mapping and the sign extension;
- agreement between the short and full views;
- the wrap of the pointer;
- the frozen sample when a strobe arrives mid-burst;
- recovery from an aborted byte.

The bench sweeps the edge values 0x000, 0x7FF, 0x800 and 0xFFF together with a series of derived patterns.

// File: rtl/accel_spi_pkg.sv
// Shared constants and helpers for the dual-resolution register file.
// Assumes measurement width of 9..16 bits so a value fits two bytes.
package accel_spi_pkg;

    localparam int SAMPLE_W = 12;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int NUM_CH   = 4;   // x, y, z, temperature
    localparam int NUM_AXES = 3;   // channels with a short view

    localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h0A;
    localparam logic [BYTE_W-1:0] CMD_READ  = 8'h0B;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_t;

    // Sign-extend one measurement to a 16-bit word.
    function automatic logic [15:0] sext16(input logic [SAMPLE_W-1:0] v);
        return {{(16-SAMPLE_W){v[SAMPLE_W-1]}}, v};
    endfunction

endpackage

// File: rtl/accel_spi_sync.sv
// Brings SCLK, chip select and MOSI into the clk domain and detects SCLK edges.
// Assumes clk is at least eight times faster than SCLK and STAGES >= 2.
module accel_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic mosi_bit
);
    logic [STAGES-1:0] sclk_q, cs_q, mosi_q;
    logic              sclk_d;

    // Synchronizer chains plus one delayed SCLK copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_q <= {sclk_q[STAGES-2:0], sclk};
            cs_q   <= {cs_q[STAGES-2:0], cs_n};
            mosi_q <= {mosi_q[STAGES-2:0], mosi};
            sclk_d <= sclk_q[STAGES-1];
        end
    end

    assign sclk_rise = sclk_q[STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_q[STAGES-1] & sclk_d;
    assign cs_active = ~cs_q[STAGES-1];
    assign mosi_bit  = mosi_q[STAGES-1];

endmodule

// File: rtl/accel_spi_proto.sv
// Frame sequencer: assembles bytes, decodes the command, walks the register
// pointer and shifts read data out. Assumes single-cycle edge pulses from the
// synchronizer and read data valid one cycle after the pointer settles.
module accel_spi_proto
    import accel_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_bit,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              snap,
    output logic              miso
);
    phase_t            phase;
    logic              is_wr;
    logic [2:0]        bitcnt;
    logic [6:0]        rx_sr;
    logic [ADDR_W-1:0] ptr;
    logic [BYTE_W-1:0] tx_sr;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;

    // Completed byte and the strobes derived from it.
    always_comb begin
        rx_byte   = {rx_sr, mosi_bit};
        byte_done = cs_active && sclk_rise && (bitcnt == 3'd7);
        snap      = byte_done && (phase == PH_ADDR);
        wr_en     = byte_done && (phase == PH_DATA) && is_wr;
    end

    assign wr_addr = ptr;
    assign wr_data = rx_byte;
    assign rd_addr = ptr;

    // Receive shift, bit counter, frame phase and register pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            phase  <= PH_CMD;
            is_wr  <= 1'b0;
            bitcnt <= 3'd0;
            rx_sr  <= '0;
            ptr    <= '0;
        end else if (sclk_rise) begin
            rx_sr  <= rx_byte[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (byte_done) begin
                unique case (phase)
                    PH_CMD: begin
                        if (rx_byte == CMD_READ) begin
                            phase <= PH_ADDR;
                            is_wr <= 1'b0;
                        end else if (rx_byte == CMD_WRITE) begin
                            phase <= PH_ADDR;
                            is_wr <= 1'b1;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_ADDR: begin
                        ptr   <= rx_byte;
                        phase <= PH_DATA;
                    end
                    PH_DATA: ptr <= ptr + 8'd1;
                    default: phase <= PH_SKIP;
                endcase
            end
        end
    end

    // Transmit shifter: loads on the falling edge that opens a byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            tx_sr <= '0;
        end else if (sclk_fall) begin
            if (bitcnt == 3'd0)
                tx_sr <= (phase == PH_DATA && !is_wr) ? rd_data : '0;
            else
                tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
    end

    // Registered output, held low outside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) miso <= 1'b0;
        else        miso <= cs_active & tx_sr[BYTE_W-1];
    end

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_DATA) |=> (ptr == $past(ptr) + 8'd1));
    assert_wr_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (is_wr && phase == PH_DATA && cs_active));
    assert_snap_then_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snap && cs_active) |=> (phase == PH_DATA || !cs_active));
    assert_skip_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP) |-> (miso == 1'b0 && !wr_en));

endmodule

// File: rtl/accel_spi_bank.sv
// Register bank: live sample, frame shadow copy, configuration bytes and the
// read multiplexer. Assumes 8-bit addressing and non-overlapping base offsets.
module accel_spi_bank
    import accel_spi_pkg::*;
#(
    parameter int MSB_BASE  = 8'h08,
    parameter int FULL_BASE = 8'h0E,
    parameter int CFG_BASE  = 8'h00,
    parameter int CFG_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sample_valid,
    input  logic [SAMPLE_W-1:0]       sample_in [NUM_CH],
    input  logic                      snap,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [BYTE_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [BYTE_W-1:0]         rd_data,
    output logic [CFG_BYTES*BYTE_W-1:0] cfg_flat
);
    logic [SAMPLE_W-1:0] live_q   [NUM_CH];
    logic [SAMPLE_W-1:0] shadow_q [NUM_CH];
    logic [BYTE_W-1:0]   cfg_q    [CFG_BYTES];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Capture the live sample on the valid strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)            live_q[c] <= '0;
            else if (sample_valid) live_q[c] <= sample_in[c];
        end

        // Freeze the frame copy when the address byte completes.
        always_ff @(posedge clk) begin
            if (!rst_n)    shadow_q[c] <= '0;
            else if (snap) shadow_q[c] <= live_q[c];
        end

        assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
            sample_valid |=> (live_q[c] == $past(sample_in[c])));
        assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !snap |=> $stable(shadow_q[c]));
    end

    for (genvar g = 0; g < CFG_BYTES; g++) begin : g_cfg
        // Writable configuration byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(CFG_BASE + g))
                cfg_q[g] <= wr_data;
        end
        assign cfg_flat[g*BYTE_W +: BYTE_W] = cfg_q[g];

        assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(cfg_q[g]));
    end

    // Read multiplexer over the shadow copy and the configuration bytes.
    always_comb begin
        logic [15:0] word;
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            word = sext16(shadow_q[i]);
            if (rd_addr == ADDR_W'(FULL_BASE + 2*i))     rd_data = word[7:0];
            if (rd_addr == ADDR_W'(FULL_BASE + 2*i + 1)) rd_data = word[15:8];
        end
        for (int i = 0; i < NUM_AXES; i++) begin
            if (rd_addr == ADDR_W'(MSB_BASE + i))
                rd_data = shadow_q[i][SAMPLE_W-1 -: BYTE_W];
        end
        for (int i = 0; i < CFG_BYTES; i++) begin
            if (rd_addr == ADDR_W'(CFG_BASE + i)) rd_data = cfg_q[i];
        end
    end

endmodule

// File: rtl/accel_spi_regs.sv
// Top level: serial register file exposing one 3-axis plus temperature sample
// as full-width byte pairs and as top-8-bit axis bytes. Assumes clk runs at
// least eight times faster than SCLK.
module accel_spi_regs
    import accel_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MSB_BASE    = 8'h08,
    parameter int FULL_BASE   = 8'h0E,
    parameter int CFG_BASE    = 8'h00,
    parameter int CFG_BYTES   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sample_valid,
    input  logic [SAMPLE_W-1:0]         accel_x,
    input  logic [SAMPLE_W-1:0]         accel_y,
    input  logic [SAMPLE_W-1:0]         accel_z,
    input  logic [SAMPLE_W-1:0]         temp_in,
    input  logic                        spi_sclk,
    input  logic                        spi_cs_n,
    input  logic                        spi_mosi,
    output logic                        spi_miso,
    output logic [CFG_BYTES*BYTE_W-1:0] cfg_bytes
);
    logic                sclk_rise, sclk_fall, cs_active, mosi_bit;
    logic [ADDR_W-1:0]   rd_addr, wr_addr;
    logic [BYTE_W-1:0]   rd_data, wr_data;
    logic                wr_en, snap;
    logic [SAMPLE_W-1:0] samples [NUM_CH];

    assign samples[0] = accel_x;
    assign samples[1] = accel_y;
    assign samples[2] = accel_z;
    assign samples[3] = temp_in;

    accel_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_active (cs_active),
        .mosi_bit  (mosi_bit)
    );

    accel_spi_proto u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_bit  (mosi_bit),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .snap      (snap),
        .miso      (spi_miso)
    );

    accel_spi_bank #(
        .MSB_BASE  (MSB_BASE),
        .FULL_BASE (FULL_BASE),
        .CFG_BASE  (CFG_BASE),
        .CFG_BYTES (CFG_BYTES)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_in    (samples),
        .snap         (snap),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .cfg_flat     (cfg_bytes)
    );

    assert_idle_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_active && $past(!cs_active)) |-> (spi_miso == 1'b0));

endmodule

// File: tb/tb_accel_spi_regs.sv
module tb_accel_spi_regs;
    localparam time HALF = 80ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sample_valid = 1'b0;
    logic [11:0] ax = '0, ay = '0, az = '0, at = '0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [31:0] cfg;

    int n_chk = 0, n_fail = 0;
    logic [7:0] rbuf [16];
    logic [7:0] b;

    always #5ns clk = ~clk;

    accel_spi_regs dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .accel_x(ax), .accel_y(ay), .accel_z(az), .temp_in(at),
        .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .cfg_bytes(cfg)
    );

    function automatic logic [7:0] lo_b(input logic [11:0] v); return v[7:0]; endfunction
    function automatic logic [7:0] hi_b(input logic [11:0] v); return {{4{v[11]}}, v[11:8]}; endfunction
    function automatic logic [7:0] ms_b(input logic [11:0] v); return v[11:4]; endfunction
    function automatic logic [11:0] pat(input int k, input int ch);
        if (k == 0) return 12'h000;
        if (k == 1) return 12'h7FF;
        if (k == 2) return 12'h800;
        if (k == 3) return 12'hFFF;
        return 12'((k * 419) + (ch * 965) + 5);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cs_lo(); cs_n = 1'b0; #(HALF); endtask
    task automatic cs_hi(); #(HALF); cs_n = 1'b1; #(4*HALF); endtask

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            #(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            #(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic rd_burst(input logic [7:0] addr, input int n);
        logic [7:0] d;
        cs_lo();
        spi_byte(8'h0B, d);
        spi_byte(addr, d);
        for (int i = 0; i < n; i++) begin
            spi_byte(8'h00, d);
            rbuf[i] = d;
        end
        cs_hi();
    endtask

    task automatic wr_burst(input logic [7:0] addr, input logic [31:0] data, input int n);
        logic [7:0] d;
        cs_lo();
        spi_byte(8'h0A, d);
        spi_byte(addr, d);
        for (int i = 0; i < n; i++) spi_byte(data[i*8 +: 8], d);
        cs_hi();
    endtask

    task automatic load(input logic [11:0] x, input logic [11:0] y,
                        input logic [11:0] z, input logic [11:0] t);
        @(posedge clk); #1ns;
        ax = x; ay = y; az = z; at = t; sample_valid = 1'b1;
        @(posedge clk); #1ns;
        sample_valid = 1'b0;
    endtask

    initial begin
        #(2_000_000ns);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] v [4];
        repeat (4) @(posedge clk);
        #1ns rst_n = 1'b1;
        #(4*HALF);

        // R1 / R12: reset state
        chk("R1 cfg after reset", cfg, 32'h0);
        chk("R12 miso idle", {31'b0, miso}, 32'h0);
        rd_burst(8'h08, 14);
        for (int i = 0; i < 14; i++) chk("R1 data zero after reset", rbuf[i], 8'h00);

        // R2 / R3 / R4 / R5: sweep of sample patterns
        for (int k = 0; k < 24; k++) begin
            for (int c = 0; c < 4; c++) v[c] = pat(k, c);
            load(v[0], v[1], v[2], v[3]);
            rd_burst(8'h08, 14);
            for (int c = 0; c < 3; c++) chk("R3 short view", rbuf[c], ms_b(v[c]));
            for (int c = 3; c < 6; c++) chk("R6 gap reads zero", rbuf[c], 8'h00);
            for (int c = 0; c < 4; c++) begin
                chk("R2 low byte", rbuf[6 + 2*c], lo_b(v[c]));
                chk("R5 R2 high byte sign", rbuf[7 + 2*c], hi_b(v[c]));
            end
            chk("R4 views agree", rbuf[0], {rbuf[7][3:0], rbuf[6][7:4]});
        end

        // R7: strobe in the middle of a burst does not disturb it
        load(12'h123, 12'h456, 12'h789, 12'hABC);
        cs_lo();
        spi_byte(8'h0B, b);
        spi_byte(8'h0E, b);
        spi_byte(8'h00, rbuf[0]);
        spi_byte(8'h00, rbuf[1]);
        load(12'hF0F, 12'h0F0, 12'h555, 12'hAAA);
        for (int i = 2; i < 8; i++) spi_byte(8'h00, rbuf[i]);
        cs_hi();
        chk("R7 frozen x lo", rbuf[0], 8'h23);
        chk("R7 frozen x hi", rbuf[1], 8'h01);
        chk("R7 frozen y lo", rbuf[2], 8'h56);
        chk("R7 frozen z hi", rbuf[5], 8'h07);
        chk("R7 frozen t hi", rbuf[7], 8'hFA);
        rd_burst(8'h0E, 2);
        chk("R7 next frame new lo", rbuf[0], 8'h0F);
        chk("R7 next frame new hi", rbuf[1], 8'hFF);

        // R8: input change without strobe is ignored
        @(posedge clk); #1ns;
        ax = 12'h001; ay = 12'h002; az = 12'h003; at = 12'h004;
        rd_burst(8'h08, 3);
        chk("R8 no strobe x", rbuf[0], 8'hF0);
        chk("R8 no strobe y", rbuf[1], 8'h0F);
        chk("R8 no strobe z", rbuf[2], 8'h55);

        // R9: configuration writes and ignored data writes
        wr_burst(8'h00, 32'hDEADBEEF, 4);
        chk("R9 cfg port", cfg, 32'hDEADBEEF);
        rd_burst(8'h00, 4);
        chk("R9 cfg readback", {rbuf[3], rbuf[2], rbuf[1], rbuf[0]}, 32'hDEADBEEF);
        wr_burst(8'h0E, 32'h0000A5A5, 2);
        rd_burst(8'h0E, 2);
        chk("R9 data write ignored lo", rbuf[0], 8'h0F);
        chk("R9 data write ignored hi", rbuf[1], 8'hFF);
        chk("R9 cfg untouched", cfg, 32'hDEADBEEF);

        // R6: pointer wraps from 0xFF to 0x00
        wr_burst(8'hFF, 32'h00221100, 3);
        chk("R6 wrap write", cfg, 32'hDEAD2211);
        rd_burst(8'hFE, 4);
        chk("R6 wrap read 0xFE", rbuf[0], 8'h00);
        chk("R6 wrap read 0x00", rbuf[2], 8'h11);
        chk("R6 wrap read 0x01", rbuf[3], 8'h22);

        // R10: unknown command writes nothing and stays silent
        cs_lo();
        spi_byte(8'h55, b);
        spi_byte(8'h00, b);
        chk("R10 miso silent addr", b, 8'h00);
        spi_byte(8'h77, b);
        chk("R10 miso silent data", b, 8'h00);
        cs_hi();
        chk("R10 no write", cfg, 32'hDEAD2211);

        // R11: partial byte is dropped, next frame clean
        cs_lo();
        spi_byte(8'h0A, b);
        spi_byte(8'h02, b);
        spi_bits(8'hFF, 4, b);
        cs_hi();
        chk("R11 partial dropped", cfg, 32'hDEAD2211);
        rd_burst(8'h02, 2);
        chk("R11 next frame read", {rbuf[1], rbuf[0]}, 32'h0000DEAD);

        // R12: idle after a frame that ended on a high bit
        rd_burst(8'h0F, 1);
        chk("R12 last byte", rbuf[0], 8'hFF);
        chk("R12 miso low idle", {31'b0, miso}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule